// File: doc/BRIEF.md
# Ethernet Transmit Serializer with Preamble, FCS and Jam

This block turns a stream of bytes from a first-word-fall-through transmit FIFO into a single serial bit stream, one bit per clock, where the clock is the transmit bit clock. A one-cycle start request opens a frame. The block then sends an alternating preamble and a two-bit sync mark. After that it sends the payload bytes as the FIFO hands them over. It closes the frame with a 32-bit frame check sequence taken straight from a serial CRC-32 register that saw every payload bit.

A collision input turns the rest of the frame into a 32-bit run of ones. A collision that arrives during the preamble is held until the preamble and sync are complete. If the FIFO runs dry before a byte marked as last has been read, the frame ends early. Each frame closes with exactly one of three one-cycle status pulses: completed, aborted or underrun. Line coding, retry and backoff belong to other blocks.

Top module: `eth_tx_serializer`

## Requirements
- R1: After reset, `tx_en_o`, `txd_o`, `fifo_rd_o` and the three status outputs are low. A `start_i` pulse while idle makes `tx_en_o` high from the next cycle on, and the first bit on the line is 1.
- R2: Every frame begins with 62 alternating bits starting with 1 (1,0,1,0,...,0), followed by the two sync bits 1,1.
- R3: Payload bytes leave least significant bit first, with no gap between them. `fifo_rd_o` is high for exactly one cycle per byte taken, while `fifo_empty_i` is low. That cycle is the one carrying the last sync bit or bit 7 of the previous byte, and `fifo_data_i` and `fifo_last_i` are captured at the end of it.
- R4: Directly after bit 7 of the byte flagged by `fifo_last_i`, 32 FCS bits follow. The FCS is the complement of a CRC-32 (polynomial 0x04C11DB7, register preset to all ones, data fed in line order), sent most significant bit first.
- R5: In the cycle after the last FCS bit, `tx_en_o` is low and `done_o` pulses for one cycle.
- R6: A collision sampled while payload or FCS bits are on the line replaces all following bits with 32 ones, starting in the next cycle. After those 32 ones, `tx_en_o` drops and `aborted_o` pulses.
- R7: A collision sampled during the preamble or sync still lets all 64 preamble and sync bits go out. Then 32 ones follow, no byte is read, and `aborted_o` pulses.
- R8: If `fifo_empty_i` is high when a byte is needed and no last-flagged byte has been taken, nothing is read. `tx_en_o` drops in the next cycle and `underrun_o` pulses.
- R9: `start_i` during a frame has no effect on that frame and does not start another one. `col_i` while idle has no effect on the line or on the next frame.
- R10: At most one status output is high in any cycle, and a status pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Frame start request, sampled while idle |
| col_i | input | 1 | Collision indication |
| fifo_data_i | input | 8 | Head byte of the transmit FIFO |
| fifo_last_i | input | 1 | Head byte is the final byte of the frame |
| fifo_empty_i | input | 1 | FIFO holds no byte |
| fifo_rd_o | output | 1 | Pop the head byte at this clock edge |
| txd_o | output | 1 | Serial transmit data |
| tx_en_o | output | 1 | High while frame bits are on the line |
| done_o | output | 1 | One-cycle pulse: frame completed with FCS |
| aborted_o | output | 1 | One-cycle pulse: frame ended by jam |
| underrun_o | output | 1 | One-cycle pulse: frame ended by FIFO underrun |

## Verification
Random frames of 1 to 20 random bytes check the bit order and the FCS. Because the bytes differ, a wrong shift direction or a wrong CRC preset, feedback or complement shows up in the stream. Collisions land at random line positions, plus four fixed ones: the first preamble bit, the last sync bit, the first payload bit and the last FCS bit. These separate the deferred jam from the immediate jam and show how many bytes were read before the abort. Underruns with zero to n-1 bytes available test the empty check both at the preamble exit and at a byte boundary. A start pulse mid-frame and a collision while idle show that both inputs are ignored outside their window.

// File: rtl/eth_txser_pkg.sv
package eth_txser_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_DATA,
        ST_FCS,
        ST_JAM
    } tx_state_e;

    typedef enum logic [1:0] {
        END_NONE,
        END_DONE,
        END_ABORT,
        END_UNDER
    } tx_end_e;

    localparam int          FCS_BITS = 32;
    localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic b);
        logic fb;
        fb = c[31] ^ b;
        return {c[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/txs_crc32.sv
module txs_crc32
    import eth_txser_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic init_i,
    input  logic feed_i,
    input  logic bit_i,
    input  logic drain_i,
    output logic msb_o
);

    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || init_i) begin
            crc_q <= CRC_SEED;
        end else if (feed_i) begin
            crc_q <= crc_step(crc_q, bit_i);
        end else if (drain_i) begin
            crc_q <= {crc_q[30:0], 1'b0};
        end
    end

    assign msb_o = crc_q[31];

endmodule

// File: rtl/txs_ctrl.sv
module txs_ctrl
    import eth_txser_pkg::*;
#(
    parameter int W        = 8,
    parameter int PRE_BITS = 62,
    parameter int JAM_BITS = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         col_i,
    input  logic [W-1:0] fifo_data_i,
    input  logic         fifo_last_i,
    input  logic         fifo_empty_i,
    output logic         fifo_rd_o,
    input  logic         crc_msb_i,
    output logic         crc_init_o,
    output logic         crc_feed_o,
    output logic         crc_bit_o,
    output logic         crc_drain_o,
    output logic         txd_o,
    output logic         tx_en_o,
    output logic         done_o,
    output logic         aborted_o,
    output logic         underrun_o
);

    localparam int CNT_W = $clog2(max2(max2(PRE_BITS + 2, JAM_BITS), max2(FCS_BITS, W)));
    localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRE_BITS + 1);
    localparam logic [CNT_W-1:0] PRE_ALT   = CNT_W'(PRE_BITS);
    localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(W - 1);
    localparam logic [CNT_W-1:0] FCS_LAST  = CNT_W'(FCS_BITS - 1);
    localparam logic [CNT_W-1:0] JAM_LAST  = CNT_W'(JAM_BITS - 1);

    tx_state_e      state_q;
    tx_end_e        end_q;
    logic [CNT_W-1:0] cnt_q;
    logic [W-1:0]   sh_q;
    logic           last_q;
    logic           col_pend_q;
    logic           col_any;
    logic           load;

    assign col_any = col_pend_q | col_i;

    always_comb begin
        load = 1'b0;
        if (state_q == ST_PRE && cnt_q == PRE_LAST && !col_any && !fifo_empty_i)
            load = 1'b1;
        if (state_q == ST_DATA && cnt_q == BYTE_LAST && !last_q && !col_i && !fifo_empty_i)
            load = 1'b1;
    end

    assign fifo_rd_o   = load;
    assign tx_en_o     = (state_q != ST_IDLE);
    assign crc_init_o  = (state_q == ST_IDLE) && start_i;
    assign crc_feed_o  = (state_q == ST_DATA);
    assign crc_bit_o   = sh_q[0];
    assign crc_drain_o = (state_q == ST_FCS);

    always_comb begin
        unique case (state_q)
            ST_PRE:  txd_o = (cnt_q >= PRE_ALT) ? 1'b1 : ~cnt_q[0];
            ST_DATA: txd_o = sh_q[0];
            ST_FCS:  txd_o = ~crc_msb_i;
            ST_JAM:  txd_o = 1'b1;
            default: txd_o = 1'b0;
        endcase
    end

    assign done_o     = (end_q == END_DONE);
    assign aborted_o  = (end_q == END_ABORT);
    assign underrun_o = (end_q == END_UNDER);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            end_q      <= END_NONE;
            cnt_q      <= '0;
            sh_q       <= '0;
            last_q     <= 1'b0;
            col_pend_q <= 1'b0;
        end else begin
            end_q <= END_NONE;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q    <= ST_PRE;
                        cnt_q      <= '0;
                        col_pend_q <= 1'b0;
                    end
                end
                ST_PRE: begin
                    if (col_i) col_pend_q <= 1'b1;
                    if (cnt_q == PRE_LAST) begin
                        cnt_q <= '0;
                        if (col_any) begin
                            state_q <= ST_JAM;
                        end else if (fifo_empty_i) begin
                            state_q <= ST_IDLE;
                            end_q   <= END_UNDER;
                        end else begin
                            state_q <= ST_DATA;
                            sh_q    <= fifo_data_i;
                            last_q  <= fifo_last_i;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (col_i) begin
                        state_q <= ST_JAM;
                        cnt_q   <= '0;
                    end else if (cnt_q == BYTE_LAST) begin
                        cnt_q <= '0;
                        if (last_q) begin
                            state_q <= ST_FCS;
                        end else if (fifo_empty_i) begin
                            state_q <= ST_IDLE;
                            end_q   <= END_UNDER;
                        end else begin
                            sh_q   <= fifo_data_i;
                            last_q <= fifo_last_i;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                        sh_q  <= sh_q >> 1;
                    end
                end
                ST_FCS: begin
                    if (col_i) begin
                        state_q <= ST_JAM;
                        cnt_q   <= '0;
                    end else if (cnt_q == FCS_LAST) begin
                        state_q <= ST_IDLE;
                        end_q   <= END_DONE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_JAM: begin
                    if (cnt_q == JAM_LAST) begin
                        state_q <= ST_IDLE;
                        end_q   <= END_ABORT;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R1
    txen_first_bit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_en_o) |-> (txd_o && $past(start_i)));

    // R3
    rd_not_empty_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_rd_o |-> !fifo_empty_i);

    // R5
    done_after_line_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!tx_en_o && $past(tx_en_o)));

    // R6
    col_to_jam_chk: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_DATA || state_q == ST_FCS) && col_i) |=> (state_q == ST_JAM));

    // R6
    abort_after_ones_chk: assert property (@(posedge clk) disable iff (rst)
        aborted_o |-> ($past(txd_o) && $past(tx_en_o)));

    // R10
    status_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done_o, aborted_o, underrun_o}));

    // R10
    status_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o || aborted_o || underrun_o) |=> !(done_o || aborted_o || underrun_o));

endmodule

// File: rtl/eth_tx_serializer.sv
module eth_tx_serializer
    import eth_txser_pkg::*;
#(
    parameter int W        = 8,
    parameter int PRE_BITS = 62,
    parameter int JAM_BITS = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         col_i,
    input  logic [W-1:0] fifo_data_i,
    input  logic         fifo_last_i,
    input  logic         fifo_empty_i,
    output logic         fifo_rd_o,
    output logic         txd_o,
    output logic         tx_en_o,
    output logic         done_o,
    output logic         aborted_o,
    output logic         underrun_o
);

    logic crc_init, crc_feed, crc_bit, crc_drain, crc_msb;

    txs_ctrl #(
        .W        (W),
        .PRE_BITS (PRE_BITS),
        .JAM_BITS (JAM_BITS)
    ) ctrl_i (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .col_i        (col_i),
        .fifo_data_i  (fifo_data_i),
        .fifo_last_i  (fifo_last_i),
        .fifo_empty_i (fifo_empty_i),
        .fifo_rd_o    (fifo_rd_o),
        .crc_msb_i    (crc_msb),
        .crc_init_o   (crc_init),
        .crc_feed_o   (crc_feed),
        .crc_bit_o    (crc_bit),
        .crc_drain_o  (crc_drain),
        .txd_o        (txd_o),
        .tx_en_o      (tx_en_o),
        .done_o       (done_o),
        .aborted_o    (aborted_o),
        .underrun_o   (underrun_o)
    );

    txs_crc32 crc_i (
        .clk     (clk),
        .rst     (rst),
        .init_i  (crc_init),
        .feed_i  (crc_feed),
        .bit_i   (crc_bit),
        .drain_i (crc_drain),
        .msb_o   (crc_msb)
    );

endmodule

// File: tb/eth_tx_serializer_tb.sv
module eth_tx_serializer_tb_top;

    localparam int M_NORM = 0;
    localparam int M_COL  = 1;
    localparam int M_UND  = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       col_i = 1'b0;
    logic [7:0] fifo_data_i = 8'h00;
    logic       fifo_last_i = 1'b0;
    logic       fifo_empty_i = 1'b1;
    logic       fifo_rd_o, txd_o, tx_en_o, done_o, aborted_o, underrun_o;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] mem [0:31];
    logic       exp_bits [0:511];
    logic       cap_bits [0:511];

    always #2 clk = ~clk;

    eth_tx_serializer dut_i (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .col_i        (col_i),
        .fifo_data_i  (fifo_data_i),
        .fifo_last_i  (fifo_last_i),
        .fifo_empty_i (fifo_empty_i),
        .fifo_rd_o    (fifo_rd_o),
        .txd_o        (txd_o),
        .tx_en_o      (tx_en_o),
        .done_o       (done_o),
        .aborted_o    (aborted_o),
        .underrun_o   (underrun_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] c;
        logic fb;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) begin
                fb = c[31] ^ mem[i][b];
                c = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
            end
        end
        return c;
    endfunction

    // builds the expected line stream, returns its length
    function automatic int build_expected(input int n, input int mode, input int prm);
        int len;
        int full;
        logic [31:0] c;
        len = 0;
        for (int i = 0; i < 62; i++) exp_bits[len++] = (i % 2 == 0);
        exp_bits[len++] = 1'b1;
        exp_bits[len++] = 1'b1;
        if (mode == M_UND) begin
            for (int i = 0; i < prm; i++)
                for (int b = 0; b < 8; b++) exp_bits[len++] = mem[i][b];
            return len;
        end
        for (int i = 0; i < n; i++)
            for (int b = 0; b < 8; b++) exp_bits[len++] = mem[i][b];
        c = ref_crc(n);
        for (int j = 0; j < 32; j++) exp_bits[len++] = ~c[31 - j];
        full = len;
        if (mode == M_COL) begin
            len = (prm < 64) ? 64 : prm + 1;
            if (len > full) len = full;
            for (int j = 0; j < 32; j++) exp_bits[len++] = 1'b1;
        end
        return len;
    endfunction

    task automatic run_frame(input int n, input int mode, input int prm,
                             input bit busy_start, input string tag);
        int exp_len, exp_pops, exp_stat, avail;
        int idx, len, pops, stat, guard, mism;
        bit pend, first;
        logic txen_s, txd_s;
        for (int i = 0; i < n; i++) mem[i] = 8'($urandom);
        exp_len  = build_expected(n, mode, prm);
        avail    = (mode == M_UND) ? prm : n;
        exp_stat = (mode == M_NORM) ? 1 : (mode == M_COL) ? 2 : 3;
        if (mode == M_UND) exp_pops = prm;
        else if (mode == M_COL) begin
            if (prm < 64) exp_pops = 0;
            else begin
                exp_pops = (prm - 63 + 7) / 8;
                if (exp_pops > n) exp_pops = n;
            end
        end else exp_pops = n;

        idx = 0; len = 0; pops = 0; stat = 0; guard = 0; pend = 0; first = 1;
        while (stat == 0 && guard < 2000) begin
            @(negedge clk);
            if (pend) idx++;
            txen_s = tx_en_o;
            txd_s  = txd_o;
            start_i      = first || (busy_start && len == 100);
            col_i        = (mode == M_COL) && txen_s && (len == prm);
            fifo_empty_i = (idx >= avail);
            fifo_data_i  = (idx < n) ? mem[idx] : 8'h00;
            fifo_last_i  = (mode != M_UND) && (idx == n - 1);
            if (txen_s && len < 512) cap_bits[len++] = txd_s;
            #1;
            pend = fifo_rd_o;
            if (pend) pops++;
            if (done_o) stat = 1;
            else if (aborted_o) stat = 2;
            else if (underrun_o) stat = 3;
            first = 0;
            guard++;
        end
        start_i = 1'b0;
        col_i   = 1'b0;
        fifo_empty_i = 1'b1;
        fifo_last_i  = 1'b0;

        mism = -1;
        for (int i = 0; i < exp_len && i < len; i++)
            if (mism < 0 && cap_bits[i] !== exp_bits[i]) mism = i;
        check(len == exp_len, {tag, " line length"}, len, exp_len);
        check(mism < 0, {tag, " first bad bit index"}, mism, -1);
        check(stat == exp_stat, {tag, " status (1 done 2 abort 3 underrun)"}, stat, exp_stat);
        check(pops == exp_pops, {tag, " bytes read"}, pops, exp_pops);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int n, mode, prm, r;
        bit ok;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1 reset state
        check(!tx_en_o && !txd_o && !fifo_rd_o && !done_o && !aborted_o && !underrun_o,
              "R1 reset outputs low", {tx_en_o, txd_o, fifo_rd_o, done_o, aborted_o, underrun_o}, 0);

        // R1 R2 R3 R4 R5 directed single-byte and multi-byte frames
        run_frame(1, M_NORM, 0, 0, "R1 R2 R3 R4 R5 one byte");
        run_frame(6, M_NORM, 0, 0, "R2 R3 R4 R5 six bytes");

        // R7 collision on first preamble bit and on last sync bit
        run_frame(4, M_COL, 0, 0, "R7 collision first preamble bit");
        run_frame(4, M_COL, 63, 0, "R7 collision last sync bit");
        // R6 collision on first payload bit and on last FCS bit
        run_frame(4, M_COL, 64, 0, "R6 collision first payload bit");
        run_frame(4, M_COL, 64 + 32 + 31, 0, "R6 collision last FCS bit");
        run_frame(4, M_COL, 71, 0, "R6 collision at byte boundary");

        // R8 underrun with nothing available and after some bytes
        run_frame(3, M_UND, 0, 0, "R8 underrun at preamble exit");
        run_frame(5, M_UND, 2, 0, "R8 underrun after two bytes");

        // R9 start during a frame is ignored
        run_frame(12, M_NORM, 0, 1, "R9 start while busy");
        ok = 1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            #1;
            if (tx_en_o || done_o || aborted_o || underrun_o) ok = 0;
        end
        check(ok, "R9 no second frame after busy start", ok, 1);

        // R9 collision while idle is ignored
        ok = 1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            col_i = 1'b1;
            #1;
            if (tx_en_o || txd_o || aborted_o) ok = 0;
        end
        @(negedge clk);
        col_i = 1'b0;
        check(ok, "R9 idle collision leaves line quiet", ok, 1);
        run_frame(3, M_NORM, 0, 0, "R9 frame after idle collision");

        // R2 R3 R4 R6 R7 R8 R10 constrained random frames
        for (int k = 0; k < 120; k++) begin
            n = 1 + int'($urandom % 20);
            r = int'($urandom % 10);
            if (r < 6) begin
                mode = M_NORM; prm = 0;
            end else if (r < 8) begin
                mode = M_COL; prm = int'($urandom % (64 + 8 * n + 32));
            end else begin
                mode = M_UND; prm = int'($urandom % n);
            end
            run_frame(n, mode, prm, 0, "R2 R3 R4 R6 R7 R8 R10 random frame");
            repeat (int'($urandom % 3)) @(negedge clk);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule